// File: doc/BRIEF.md
# Bit Read-Modify-Write Engine

This block performs single-bit updates on a byte-wide store that models the bit-addressable part of a microcontroller's data space: sixteen general RAM bytes and sixteen special-register bytes. A requester presents an 8-bit bit address, a 3-bit operation code and a carry input. The engine splits the bit address into a byte address and a bit index. It then reads the byte, changes only the selected bit, and writes the byte back. It returns the value the bit held before the update.

Each request runs as a fixed-length sequence. There are two cycles to fetch and modify the byte, a wait of zero or more cycles that sets the total length, and a single write-back cycle. During the write-back cycle a done pulse is raised. In that same cycle the written byte, its byte address and the old bit value are all visible. Only one request is in flight at a time. A request offered while the engine is busy is dropped.

Top module: `bitop_rmw_unit`

## Requirements
- R1: After reset, busy and done are low and every bit of the store reads as 0.
- R2: A bit address below 0x80 selects byte 0x20 plus bits [6:3] of the address, and bit index bits [2:0]. For example, 0x00 selects byte 0x20 bit 0, and 0x7F selects byte 0x2F bit 7. During done, wb_addr shows that byte address.
- R3: A bit address of 0x80 or above selects the register byte whose address is the bit address with bits [2:0] cleared, and bit index bits [2:0]. For example, 0xFF selects byte 0xF8 bit 7.
- R4: Op code 0 clears the bit and code 1 sets it. Code 2 inverts it. Code 3 copies the carry input that was sampled in the accept cycle; later changes to carry_in have no effect.
- R5: Op code 4 (test-and-clear) reports the bit's old value on old_bit and writes the bit as 0.
- R6: The seven unselected bits of the byte are written back unchanged; wb_byte carries the whole written byte during done.
- R7: During done, old_bit equals the selected bit's value before this request.
- R8: The accept cycle counts as cycle 1. Done is high in cycle 6 for op code 2 and in cycle 4 for every other code, and it is high for exactly one cycle.
- R9: A request is accepted only while busy is low. Busy is high from the cycle after acceptance through the done cycle, and requests offered while busy produce no operation.
- R10: Op codes 5, 6 and 7 write the byte back unchanged and take 4 cycles like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered this cycle |
| req_op | input | 3 | Operation code (0 clear, 1 set, 2 invert, 3 copy carry, 4 test-and-clear, 5-7 no change) |
| req_bitaddr | input | 8 | Bit address |
| carry_in | input | 1 | Carry value used by op code 3, sampled at acceptance |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Write-back cycle pulse |
| wb_addr | output | 8 | Byte address being written back |
| wb_byte | output | 8 | Byte value being written back |
| old_bit | output | 1 | Selected bit before the update |

## Verification
The checker assumes that a request is honoured only when it coincides with busy low. It ties each done pulse to the request captured at that moment, which is valid because at most one request can be in flight. The stimulus keeps to this by waiting for busy to fall before it asserts req_valid, and it drops req_valid one cycle later. The one exception is a deliberate burst of requests held only during busy cycles; that burst is released in the done cycle, before the engine returns to idle. A carry value that flips right after acceptance confirms that only the sampled carry is used.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
package bitop_pkg;

    typedef enum logic [2:0] {
        BOP_CLR  = 3'd0,
        BOP_SET  = 3'd1,
        BOP_CPL  = 3'd2,
        BOP_MOVC = 3'd3,
        BOP_TCLR = 3'd4,
        BOP_RSV5 = 3'd5,
        BOP_RSV6 = 3'd6,
        BOP_RSV7 = 3'd7
    } bop_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_MODIFY = 3'd2,
        ST_HOLD   = 3'd3,
        ST_WRITE  = 3'd4
    } seq_e;

    localparam int          ROW_W        = 4;            // rows per bank = 2**ROW_W
    localparam int          SLOT_W       = ROW_W + 1;    // bank select + row
    localparam logic [7:0]  BIT_RAM_BASE = 8'h20;
    localparam int          MIN_SEQ_CYC  = 4;            // accept, read, modify, write

    typedef struct packed {
        logic [7:0]        byte_addr;
        logic [SLOT_W-1:0] slot;
        logic [2:0]        bit_idx;
    } bloc_t;

    typedef struct packed {
        logic [7:0] new_byte;
        logic       old_bit;
    } rmw_t;

    function automatic bloc_t map_bitaddr(input logic [7:0] ba);
        bloc_t l;
        l.bit_idx = ba[2:0];
        l.slot    = {ba[7], ba[6:3]};
        l.byte_addr = ba[7] ? {ba[7:3], 3'b000}
                            : (BIT_RAM_BASE + {4'b0000, ba[6:3]});
        return l;
    endfunction

    function automatic rmw_t apply_bitop(input logic [7:0] cur,
                                         input logic [2:0] idx,
                                         input bop_e       op,
                                         input logic       cin);
        rmw_t r;
        r.old_bit  = cur[idx];
        r.new_byte = cur;
        case (op)
            BOP_CLR:  r.new_byte[idx] = 1'b0;
            BOP_SET:  r.new_byte[idx] = 1'b1;
            BOP_CPL:  r.new_byte[idx] = ~cur[idx];
            BOP_MOVC: r.new_byte[idx] = cin;
            BOP_TCLR: r.new_byte[idx] = 1'b0;
            default:  r.new_byte      = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitop_addr_map.sv
`timescale 1ns/1ps
module bitop_addr_map
    import bitop_pkg::*;
(
    input  logic [7:0] bitaddr,
    output bloc_t      loc
);
    always_comb loc = map_bitaddr(bitaddr);
endmodule

// File: rtl/bitop_store.sv
`timescale 1ns/1ps
module bitop_store #(
    parameter int ROWS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(ROWS):0]       rd_slot,
    output logic [7:0]                  rd_byte,
    input  logic                        wr_en,
    input  logic [$clog2(ROWS):0]       wr_slot,
    input  logic [7:0]                  wr_byte
);
    localparam int RW = $clog2(ROWS);
    localparam int NUM_BANKS = 2;   // bank 0: general RAM bits, bank 1: register bits

    logic [7:0] bank_rd [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [7:0] rows [ROWS];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < ROWS; i++) rows[i] <= 8'h00;
            end else if (wr_en && (wr_slot[RW] == 1'(g))) begin
                rows[wr_slot[RW-1:0]] <= wr_byte;
            end
        end
        assign bank_rd[g] = rows[rd_slot[RW-1:0]];
    end

    assign rd_byte = bank_rd[rd_slot[RW]];
endmodule

// File: rtl/bitop_seq.sv
`timescale 1ns/1ps
module bitop_seq
    import bitop_pkg::*;
#(
    parameter int EXTRA_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [EXTRA_W-1:0] extra_wait,
    output seq_e               state
);
    logic [EXTRA_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_READ;
                ST_READ:   state <= ST_MODIFY;
                ST_MODIFY: begin
                    if (extra_wait == '0) begin
                        state <= ST_WRITE;
                    end else begin
                        state <= ST_HOLD;
                        cnt   <= extra_wait - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) state <= ST_WRITE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_WRITE:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bitop_rmw_unit.sv
`timescale 1ns/1ps
module bitop_rmw_unit
    import bitop_pkg::*;
#(
    parameter int FAST_OP_CYCLES = 4,
    parameter int CPL_OP_CYCLES  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  logic [7:0] req_bitaddr,
    input  logic       carry_in,
    output logic       busy,
    output logic       done,
    output logic [7:0] wb_addr,
    output logic [7:0] wb_byte,
    output logic       old_bit
);
    localparam int FAST_EXTRA = FAST_OP_CYCLES - MIN_SEQ_CYC;
    localparam int CPL_EXTRA  = CPL_OP_CYCLES  - MIN_SEQ_CYC;
    localparam int EXTRA_W    = $clog2(FAST_OP_CYCLES + CPL_OP_CYCLES + 1);
    localparam int ROWS       = 2 ** ROW_W;

    seq_e               state;
    logic               accept;
    bop_e               op_q;
    logic [7:0]         ba_q;
    logic               cin_q;
    logic [7:0]         rd_byte;
    logic [7:0]         byte_q;
    rmw_t               res_q;
    bloc_t              loc;
    logic [EXTRA_W-1:0] extra_sel;

    assign accept    = req_valid && (state == ST_IDLE);
    assign extra_sel = (op_q == BOP_CPL) ? EXTRA_W'(CPL_EXTRA) : EXTRA_W'(FAST_EXTRA);

    bitop_addr_map u_map (
        .bitaddr (ba_q),
        .loc     (loc)
    );

    bitop_seq #(.EXTRA_W(EXTRA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .extra_wait (extra_sel),
        .state      (state)
    );

    bitop_store #(.ROWS(ROWS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_slot (loc.slot),
        .rd_byte (rd_byte),
        .wr_en   (state == ST_WRITE),
        .wr_slot (loc.slot),
        .wr_byte (res_q.new_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= BOP_CLR;
            ba_q   <= 8'h00;
            cin_q  <= 1'b0;
            byte_q <= 8'h00;
            res_q  <= '0;
        end else begin
            if (accept) begin
                op_q  <= bop_e'(req_op);
                ba_q  <= req_bitaddr;
                cin_q <= carry_in;
            end
            if (state == ST_READ)   byte_q <= rd_byte;
            if (state == ST_MODIFY) res_q  <= apply_bitop(byte_q, loc.bit_idx, op_q, cin_q);
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_WRITE);
    assign wb_addr = loc.byte_addr;
    assign wb_byte = res_q.new_byte;
    assign old_bit = res_q.old_bit;
endmodule

// File: rtl/bitop_rmw_checks.sv
`timescale 1ns/1ps
module bitop_rmw_checks
    import bitop_pkg::*;
#(
    parameter int FAST_OP_CYCLES = 4,
    parameter int CPL_OP_CYCLES  = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [7:0] req_bitaddr,
    input logic       carry_in,
    input logic       busy,
    input logic       done,
    input logic [7:0] wb_addr,
    input logic [7:0] wb_byte,
    input logic       old_bit
);
    logic [2:0] op_c;
    logic [7:0] ba_c;
    logic       cin_c;
    logic [7:0] cyc_c;
    logic [7:0] exp_addr;
    logic [2:0] idx_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_c <= 3'd0; ba_c <= 8'h00; cin_c <= 1'b0; cyc_c <= 8'd0;
        end else if (req_valid && !busy) begin
            op_c <= req_op; ba_c <= req_bitaddr; cin_c <= carry_in; cyc_c <= 8'd2;
        end else if (busy) begin
            cyc_c <= cyc_c + 8'd1;
        end
    end

    assign idx_c    = ba_c[2:0];
    assign exp_addr = ba_c[7] ? (ba_c & 8'hF8) : (8'h20 | {4'b0000, ba_c[6:3]});

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle");

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc_c == ((op_c == 3'(BOP_CPL)) ? 8'(CPL_OP_CYCLES) : 8'(FAST_OP_CYCLES))))
        else $error("wrong sequence length");

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy) else $error("idle request not taken");

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy) else $error("done while idle");

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy) else $error("busy dropped early");

    // covers R3 as well: register-area addresses
    assert_wb_addr_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (wb_addr == exp_addr)) else $error("wrong byte address");

    assert_set_R4: assert property (@(posedge clk) disable iff (rst)
        (done && op_c == 3'(BOP_SET)) |-> wb_byte[idx_c]) else $error("set failed");

    assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (done && op_c == 3'(BOP_MOVC)) |-> (wb_byte[idx_c] == cin_c)) else $error("carry copy failed");

    assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
        (done && op_c == 3'(BOP_CPL)) |-> (wb_byte[idx_c] != old_bit)) else $error("invert failed");

    assert_tclr_R5: assert property (@(posedge clk) disable iff (rst)
        (done && (op_c == 3'(BOP_TCLR) || op_c == 3'(BOP_CLR))) |-> !wb_byte[idx_c])
        else $error("clear failed");
endmodule

bind bitop_rmw_unit bitop_rmw_checks #(
    .FAST_OP_CYCLES (FAST_OP_CYCLES),
    .CPL_OP_CYCLES  (CPL_OP_CYCLES)
) u_chk (.*);

// File: tb/sim_bitop_rmw_unit.sv
`timescale 1ns/1ps
module sim_bitop_rmw_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_op;
    logic [7:0] req_bitaddr;
    logic       carry_in;
    logic       busy, done, old_bit;
    logic [7:0] wb_addr, wb_byte;

    always #2.5 clk = ~clk;

    bitop_rmw_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bitaddr(req_bitaddr), .carry_in(carry_in), .busy(busy),
        .done(done), .wb_addr(wb_addr), .wb_byte(wb_byte), .old_bit(old_bit)
    );

    typedef struct {
        int         due;
        logic [7:0] addr;
        logic [7:0] data;
        logic       old;
        logic [2:0] idx;
        int         op;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] model [256];
    int checks = 0, failures = 0, cyc = 0, pushed = 0, seen = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver: pushes the expected outcome, then offers the request
    task automatic run_op(input logic [2:0] op, input logic [7:0] ba, input logic c);
        exp_t e;
        logic [7:0] cur, nb, baddr;
        logic [2:0] idx;
        @(negedge clk);
        while (busy) @(negedge clk);
        baddr = ba[7] ? {ba[7:3], 3'b000} : (8'h20 + {4'b0000, ba[6:3]});
        idx   = ba[2:0];
        cur   = model[baddr];
        nb    = cur;
        case (op)
            3'd0: nb[idx] = 1'b0;
            3'd1: nb[idx] = 1'b1;
            3'd2: nb[idx] = ~cur[idx];
            3'd3: nb[idx] = c;
            3'd4: nb[idx] = 1'b0;
            default: nb = cur;
        endcase
        e.due  = cyc + ((op == 3'd2) ? 6 : 4) - 1;
        e.addr = baddr; e.data = nb; e.old = cur[idx]; e.idx = idx; e.op = op;
        sb_q.push_back(e);
        pushed++;
        model[baddr] = nb;
        req_valid = 1'b1; req_op = op; req_bitaddr = ba; carry_in = c;
        @(negedge clk);
        req_valid = 1'b0;
        carry_in  = ~c;   // must not matter after acceptance (R4)
    endtask

    // monitor: pops and compares on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            seen++;
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                logic [7:0] keep;
                e = sb_q.pop_front();
                keep = ~(8'h01 << e.idx);
                check(e.addr[7] ? "R3 wb_addr" : "R2 wb_addr", wb_addr, e.addr);
                check((e.op >= 5) ? "R10 wb_byte" : (e.op == 4) ? "R5 wb_byte" : "R4 wb_byte",
                      wb_byte, e.data);
                check("R6 unselected bits", wb_byte & keep, e.data & keep);
                check((e.op == 4) ? "R5 old_bit" : "R7 old_bit", old_bit, e.old);
                check("R8 done cycle", cyc, e.due);
            end
        end
    end

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        rst = 1'b1; req_valid = 1'b0; req_op = 3'd0; req_bitaddr = 8'h00; carry_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);

        // R1: first touch of several bytes reports 0 (old_bit checked by monitor)
        run_op(3'd4, 8'h00, 1'b0);
        run_op(3'd4, 8'hF8, 1'b0);
        // R2 / R3 boundary addresses
        run_op(3'd1, 8'h00, 1'b0);
        run_op(3'd1, 8'h7F, 1'b0);
        run_op(3'd1, 8'h80, 1'b0);
        run_op(3'd1, 8'hFF, 1'b0);
        // R4 invert twice, carry copy both ways
        run_op(3'd2, 8'h0B, 1'b0);
        run_op(3'd2, 8'h0B, 1'b1);
        run_op(3'd3, 8'h13, 1'b1);
        run_op(3'd3, 8'h13, 1'b0);
        run_op(3'd3, 8'h13, 1'b1);
        // R5 test-and-clear on a set bit then a clear bit
        run_op(3'd4, 8'h7F, 1'b1);
        run_op(3'd4, 8'h7F, 1'b1);
        // R6: fill one byte then clear one bit
        for (int b = 0; b < 8; b++) run_op(3'd1, 8'h20 + 8'(b), 1'b0);
        run_op(3'd0, 8'h23, 1'b0);
        run_op(3'd2, 8'hC5, 1'b0);
        // R10 reserved codes
        run_op(3'd5, 8'h21, 1'b0);
        run_op(3'd6, 8'hC5, 1'b1);
        run_op(3'd7, 8'h8A, 1'b1);

        // R9: requests held only while busy must be dropped
        run_op(3'd0, 8'h30, 1'b0);
        forever begin
            @(negedge clk);
            if (done || !busy) begin req_valid = 1'b0; break; end
            req_valid = 1'b1; req_op = 3'd1; req_bitaddr = 8'h50;
        end
        drain();
        check("R9 done count vs accepted", seen, pushed);
        run_op(3'd4, 8'h50, 1'b0);   // bit must still be 0
        drain();

        // mixed traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_op(lfsr[2:0], lfsr[10:3], lfsr[11]);
        end
        drain();
        check("R9 final done count", seen, pushed);
        check("R8 done idle at end", done, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule